// File: doc/BRIEF.md
# Serial Back-Channel Message Accumulator

This block collects a message that a keyboard or pointing device sends back one bit at a time on a single attention line. Once per display scan line a strobe marks the moment to sample the line. A high level is taken as a 1 and a low level as a 0. The bits build up in two 16-bit registers, an upper word and a lower word. There is no bit counter. The first 1 seen on the line acts as a start marker. It walks down the upper word, and when it reaches the least significant bit the upper word is full. From then on, a one-hot marker in the lower word records how far the tail of the message has progressed.

A message is 24 bits long, counting the leading 1. The first bit received ends in the least significant bit of the upper word. The last eight bits fill bits 15 down to 8 of the lower word, and the marker comes to rest in bit 7. At that point the block raises a valid flag and holds both words steady. The consumer reads the words and pulses acknowledge, which clears the block so the next message can start. Decoding the meaning of the message fields is left to the consumer.

Top module: `serial_msg_accum`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the upper word, the lower word and the valid flag to 0.
- R2: While bit 0 of the upper word is 0 and valid is low, each strobe shifts the upper word right by one, puts the sampled bit into bit 15, and loads the lower word with 0x8000.
- R3: While bit 0 of the upper word is 1 and valid is low, each strobe shifts the lower word right by one and puts the sampled bit into bit 15. The upper word keeps its value.
- R4: Valid rises on the strobe that moves the lower-word marker into bit 7, which is the 24th bit counted from the leading 1. With the message bits m[0] (first) to m[23] (last), the upper word then reads m[15:0] and the lower word reads {m[23:16], 8'h80}.
- R5: While valid is high and acknowledge is low, strobes are ignored: both words and valid stay unchanged.
- R6: Acknowledge while valid is high clears both words and valid at the next clock edge.
- R7: Acknowledge while valid is low has no effect on either word or on valid.
- R8: With no strobe and no accepted acknowledge, both words hold their values.
- R9: Zeros that arrive before the first 1 leave the upper word at 0, so the message starts only at the leading 1.
- R10: When acknowledge and a strobe arrive in the same cycle while valid is high, the acknowledge wins and the sample is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| attnLine | input | 1 | Serial attention line, level sampled on a strobe |
| lineStrobe | input | 1 | One-cycle pulse, once per scan line, that samples the line |
| msgAck | input | 1 | Consumer acknowledge; clears a completed message |
| msgUpper | output | 16 | Upper message word |
| msgLower | output | 16 | Lower message word with the progress marker |
| msgValid | output | 1 | Message complete and held |

## Verification
The bench builds the block with its default values: 16-bit upper and lower words and an 8-bit tail. This gives a 24-bit message whose end marker sits at bit 7. With these widths, every position the start marker and the tail marker pass through can be reached in a few dozen strobes. That covers the handover from the upper to the lower word, the final strobe that raises valid, and the minimal message 0x000001, where the only 1 is the start bit. Each message is sent with an idle cycle between bits. The bench also sends strobes and acknowledges in the posted state, including both in the same cycle.

// File: rtl/serial_msg_accum_pkg.sv
package serial_msg_accum_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic stepUp;   // shift the upper word and reload the marker
    logic stepLo;   // shift the lower word
    logic clear;    // wipe both words after acknowledge
  } accumCtrl_t;
endpackage

// File: rtl/serial_msg_accum_dp.sv
module serial_msg_accum_dp
  import serial_msg_accum_pkg::*;
#(
  parameter int UPPER_W   = 16,
  parameter int LOWER_W   = 16,
  parameter int TAIL_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               attnLine,
  input  accumCtrl_t         ctrl,
  output logic               upFull,
  output logic               tailLast,
  output logic [UPPER_W-1:0] upWord,
  output logic [LOWER_W-1:0] loWord
);
  localparam int DONE_POS = LOWER_W - 1 - TAIL_BITS;
  localparam logic [LOWER_W-1:0] MARKER = {1'b1, {(LOWER_W-1){1'b0}}};

  logic [UPPER_W-1:0] upReg;
  logic [LOWER_W-1:0] loReg;

  always_ff @(posedge clk) begin
    if (rst || ctrl.clear) begin
      upReg <= '0;
      loReg <= '0;
    end else if (ctrl.stepUp) begin
      upReg <= {attnLine, upReg[UPPER_W-1:1]};
      loReg <= MARKER;
    end else if (ctrl.stepLo) begin
      loReg <= {attnLine, loReg[LOWER_W-1:1]};
    end
  end

  assign upFull   = upReg[0];
  assign tailLast = loReg[DONE_POS+1];
  assign upWord   = upReg;
  assign loWord   = loReg;

  // R8: without any strobe from the control, both words hold
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.stepUp && !ctrl.stepLo && !ctrl.clear) |=> ($stable(upReg) && $stable(loReg)));

  // R2: a step of the upper word leaves the marker in the lower word
  assert_marker_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl.stepUp |=> (loReg == MARKER));

  // R3: a step of the lower word does not touch the upper word
  assert_up_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    ctrl.stepLo |=> $stable(upReg));
endmodule

// File: rtl/serial_msg_accum_ctrl.sv
module serial_msg_accum_ctrl
  import serial_msg_accum_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lineStrobe,
  input  logic       msgAck,
  input  logic       upFull,
  input  logic       tailLast,
  output accumCtrl_t ctrl,
  output logic       validOut
);
  logic validReg;
  logic sampleOk;

  always_comb begin
    sampleOk    = lineStrobe && !validReg;
    ctrl.clear  = validReg && msgAck;
    ctrl.stepUp = sampleOk && !upFull;
    ctrl.stepLo = sampleOk && upFull;
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clear)
      validReg <= 1'b0;
    else if (ctrl.stepLo && tailLast)
      validReg <= 1'b1;
  end

  assign validOut = validReg;

  // R5: a posted message stays posted until acknowledged
  assert_valid_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (validReg && !msgAck) |=> validReg);

  // R6: acknowledge of a posted message drops valid
  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (validReg && msgAck) |=> !validReg);

  // R10: no datapath step while a message is posted
  assert_no_step_posted_R10: assert property (@(posedge clk) disable iff (rst)
    validReg |-> !(ctrl.stepUp || ctrl.stepLo));
endmodule

// File: rtl/serial_msg_accum.sv
module serial_msg_accum
  import serial_msg_accum_pkg::*;
#(
  parameter int UPPER_W   = 16,
  parameter int LOWER_W   = 16,
  parameter int TAIL_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               attnLine,
  input  logic               lineStrobe,
  input  logic               msgAck,
  output logic [UPPER_W-1:0] msgUpper,
  output logic [LOWER_W-1:0] msgLower,
  output logic               msgValid
);
  localparam int DONE_POS = LOWER_W - 1 - TAIL_BITS;

  accumCtrl_t ctrl;
  logic       upFull;
  logic       tailLast;

  serial_msg_accum_ctrl u_ctrl (
    .clk(clk), .rst(rst), .lineStrobe(lineStrobe), .msgAck(msgAck),
    .upFull(upFull), .tailLast(tailLast), .ctrl(ctrl), .validOut(msgValid)
  );

  serial_msg_accum_dp #(.UPPER_W(UPPER_W), .LOWER_W(LOWER_W), .TAIL_BITS(TAIL_BITS)) u_dp (
    .clk(clk), .rst(rst), .attnLine(attnLine), .ctrl(ctrl),
    .upFull(upFull), .tailLast(tailLast), .upWord(msgUpper), .loWord(msgLower)
  );

  // R4: valid only rises with the marker sitting at the done position
  assert_rise_done_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(msgValid) |-> (msgLower[DONE_POS] && msgUpper[0]));

  // R7: acknowledge with nothing posted changes nothing
  assert_idle_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (!msgValid && msgAck && !lineStrobe) |=> ($stable(msgUpper) && $stable(msgLower) && !msgValid));
endmodule

// File: tb/serial_msg_accum_tb.sv
module serial_msg_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        attnLine = 1'b0;
  logic        lineStrobe = 1'b0;
  logic        msgAck = 1'b0;
  logic [15:0] msgUpper;
  logic [15:0] msgLower;
  logic        msgValid;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  serial_msg_accum dut_i (
    .clk(clk), .rst(rst), .attnLine(attnLine), .lineStrobe(lineStrobe),
    .msgAck(msgAck), .msgUpper(msgUpper), .msgLower(msgLower), .msgValid(msgValid)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk);
    attnLine = b;
    lineStrobe = 1'b1;
    @(negedge clk);
    lineStrobe = 1'b0;
  endtask

  task automatic pulseAck(input logic withStrobe, input logic b);
    @(negedge clk);
    msgAck = 1'b1;
    lineStrobe = withStrobe;
    attnLine = b;
    @(negedge clk);
    msgAck = 1'b0;
    lineStrobe = 1'b0;
  endtask

  task automatic testReset;
    check("R1 upper", msgUpper, 0);
    check("R1 lower", msgLower, 0);
    check("R1 valid", msgValid, 0);
  endtask

  task automatic testIdleZeros;
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    check("R9 upper after zeros", msgUpper, 0);
    check("R2 lower marker", msgLower, 16'h8000);
    pulseAck(1'b0, 1'b0);
    check("R7 upper", msgUpper, 0);
    check("R7 lower", msgLower, 16'h8000);
    check("R7 valid", msgValid, 0);
  endtask

  task automatic testFullMessage(input logic [23:0] m, input string name);
    for (int i = 0; i < 24; i++) begin
      sendBit(m[i]);
      if (i == 0) check({"R2 first bit ", name}, msgUpper, 16'h8000);
      if (i == 15) begin
        check({"R2 upper full ", name}, msgUpper, m[15:0]);
        check({"R2 lower marker ", name}, msgLower, 16'h8000);
      end
      if (i == 16) begin
        check({"R3 upper held ", name}, msgUpper, m[15:0]);
        check({"R3 lower step ", name}, msgLower, m[16] ? 16'hC000 : 16'h4000);
      end
      if (i == 22) check({"R4 not yet valid ", name}, msgValid, 0);
    end
    check({"R4 valid ", name}, msgValid, 1);
    check({"R4 upper ", name}, msgUpper, m[15:0]);
    check({"R4 lower ", name}, msgLower, {m[23:16], 8'h80});
  endtask

  task automatic testIgnoreWhilePosted(input logic [23:0] m);
    sendBit(1'b1);
    sendBit(1'b0);
    check("R5 upper", msgUpper, m[15:0]);
    check("R5 lower", msgLower, {m[23:16], 8'h80});
    check("R5 valid", msgValid, 1);
    repeat (4) @(negedge clk);
    check("R8 upper stable", msgUpper, m[15:0]);
  endtask

  task automatic testAck;
    pulseAck(1'b0, 1'b0);
    check("R6 upper", msgUpper, 0);
    check("R6 lower", msgLower, 0);
    check("R6 valid", msgValid, 0);
  endtask

  task automatic testAckWithStrobe;
    pulseAck(1'b1, 1'b1);
    check("R10 upper", msgUpper, 0);
    check("R10 lower", msgLower, 0);
    check("R10 valid", msgValid, 0);
    sendBit(1'b1);
    check("R10 restart", msgUpper, 16'h8000);
  endtask

  task automatic testResetMid;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset upper", msgUpper, 0);
    check("R1 mid reset lower", msgLower, 0);
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testIdleZeros();
    testFullMessage(24'hA5C35B, "A");
    testIgnoreWhilePosted(24'hA5C35B);
    testAck();
    testFullMessage(24'h000001, "min");
    testAckWithStrobe();
    testResetMid();
    testFullMessage(24'hFFFFFF, "ones");
    testAck();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule